// File: doc/BRIEF.md
# Metering Calibration Order Controller

This block sequences the calibration of one metering channel. A single `go` pulse makes it walk through offset removal, optional AC offset calibration, gain calibration and a final AC offset correction, in an order that depends on whether the channel's high-pass filter is in use. The controller does no arithmetic of its own apart from one fixed-point scaling. It starts three external calibration units (DC offset, AC offset, gain) with one-cycle pulses and waits for each one's `done`. It also presets the channel's offset and gain registers through a write channel.

The configuration (`cfg_hpf`, `cfg_ac_req`, `cfg_fix_mul`) is captured on the accepted `go` edge. Changes made later have no effect until the next run. A DC-gain request on a filtered channel is refused, because those two settings conflict. A calibration unit that never answers makes the run abort after `TMO_CYC` waiting cycles.

The register write channel follows valid/ready rules. `wr_valid` rises with `wr_sel` and `wr_data` already set, and all three stay unchanged until a cycle in which `wr_ready` is high. That cycle is the transfer, and the controller moves on at the following edge. `wr_ready` may stay low for any number of cycles, and the sequence stalls until it rises. Register select codes are 0 for the DC offset register, 1 for the AC offset register and 2 for the gain register.

Top module: `calseq_ctrl`

## Requirements
- R1: `go` seen high while idle makes `busy` rise at the next edge. Every run ends with `fin` high for exactly one cycle while `busy` is still high, and `busy` is low in the cycle after. A `go` seen while `busy` is high is ignored.
- R2: With `cfg_hpf`=1 the first action is a write of 0 to register select 0 (DC offset), and `dco_start` never pulses during that run.
- R3: With `cfg_hpf`=0 the first action is a write of unity gain (2^GFRAC) to register select 2, followed by one `dco_start` pulse.
- R4: `aco_start` pulses after the offset step only when `cfg_ac_req`=1. With `cfg_ac_req`=0 the run has no AC offset start and no AC offset write.
- R5: Exactly one `gain_start` pulse follows the offset steps. Start pulses last one cycle, and no two of them are ever high together.
- R6: With AC offset requested and `cfg_fix_mul`=0, gain calibration is followed by a write of 0 to register select 1 and then a second `aco_start`.
- R7: With AC offset requested and `cfg_fix_mul`=1, gain calibration is followed by one write to register select 1. The written value is floor((aco_val × gain_val) / 2^GFRAC), where `aco_val` is signed two's complement and `gain_val` is unsigned with GFRAC fraction bits.
- R8: The product written under R7 saturates to the signed DW-bit range, at 2^(DW-1)-1 on the high side and -2^(DW-1) on the low side.
- R9: `go` with `cfg_dc_gain`=1 and `cfg_hpf`=1 is refused. `fin` comes at the next cycle with `err`=1 and `err_code`=1, and there are no starts and no writes.
- R10: After a start pulse the controller waits up to `TMO_CYC` cycles for the matching `done`. A `done` in the last of those cycles still counts. If none arrives, the run aborts, `fin` rises `TMO_CYC`+1 cycles after the start pulse, `err`=1 and `err_code`=2, and no further starts or writes follow.
- R11: Each write is a single transfer. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_sel` and `wr_data` hold their values.
- R12: After reset `busy`, `fin`, `err`, `wr_valid` and all start pulses are low and `err_code` is 0. `err` and `err_code` keep their values until the next accepted `go`, which clears them unless that `go` is refused.
- R13: The configuration inputs are sampled only on the accepted `go`. Changing them during a run does not alter that run's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a calibration run |
| busy | output | 1 | A run is in progress |
| fin | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run was refused or aborted |
| err_code | output | 2 | 0 none, 1 refused configuration, 2 timeout |
| cfg_hpf | input | 1 | High-pass filter in use on the channel |
| cfg_ac_req | input | 1 | AC offset calibration requested |
| cfg_dc_gain | input | 1 | DC gain calibration mode selected |
| cfg_fix_mul | input | 1 | AC offset correction: 0 rerun, 1 multiply |
| aco_val | input | DW | Current AC offset value, signed |
| gain_val | input | DW | Newly calibrated gain, unsigned fixed point |
| dco_start | output | 1 | Start pulse to the DC offset unit |
| dco_done | input | 1 | DC offset unit finished |
| aco_start | output | 1 | Start pulse to the AC offset unit |
| aco_done | input | 1 | AC offset unit finished |
| gain_start | output | 1 | Start pulse to the gain unit |
| gain_done | input | 1 | Gain unit finished |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write accepted |
| wr_sel | output | 2 | Register select: 0 DC offset, 1 AC offset, 2 gain |
| wr_data | output | DW | Register write value |

## Verification
A corrupted sequencing state shows at the ports as an out-of-order or missing start pulse or register write, visible in the next cycle the controller acts. It also shows as a `fin` that arrives early or never. A damaged wait counter shifts the abort point, so `fin` moves away from exactly `TMO_CYC`+1 cycles after the stalled start pulse. An error in the scaling path appears as a wrong AC offset write value in the cycle the multiply correction is offered. A sign or saturation slip shows most clearly at the two range limits.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  typedef enum logic [1:0] {
    SEL_DCO  = 2'd0,
    SEL_ACO  = 2'd1,
    SEL_GAIN = 2'd2
  } wsel_e;

  typedef enum logic [1:0] {
    EC_NONE = 2'd0,
    EC_CFG  = 2'd1,
    EC_TMO  = 2'd2
  } ecode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ZERO_DCO,
    ST_UNIT_GAIN,
    ST_KICK_DCO,
    ST_WAIT_DCO,
    ST_KICK_ACO,
    ST_WAIT_ACO,
    ST_KICK_GAIN,
    ST_WAIT_GAIN,
    ST_ZERO_ACO,
    ST_KICK_RERUN,
    ST_WAIT_RERUN,
    ST_SCALE,
    ST_PUT_PROD,
    ST_END
  } st_e;

  // run plan captured on the accepted start
  typedef struct packed {
    logic ac_req;
    logic fix_mul;
  } plan_t;

endpackage

// File: rtl/calseq_tmo.sv
// Wait-window counter: cleared on each kick, counts waiting cycles.
module calseq_tmo #(
  parameter int unsigned TMO_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (run && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // high in the last permitted waiting cycle
  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/calseq_ofs_scale.sv
// Signed offset times unsigned fixed-point gain, floor shift, saturate.
module calseq_ofs_scale #(
  parameter int unsigned DW    = 24,
  parameter int unsigned GFRAC = 22
) (
  input  logic [DW-1:0] ofs_in,
  input  logic [DW-1:0] gain_in,
  output logic [DW-1:0] ofs_out
);
  localparam int unsigned PW = 2*DW + 1;
  localparam int unsigned HW = PW - (DW - 1);

  logic signed [PW-1:0] a_ext, g_ext, prod, shr;
  logic [HW-1:0]        top_bits;
  logic                 in_range;

  assign a_ext    = PW'($signed(ofs_in));
  assign g_ext    = PW'($signed({1'b0, gain_in}));
  assign prod     = a_ext * g_ext;
  assign shr      = prod >>> GFRAC;
  assign top_bits = shr[PW-1:DW-1];
  assign in_range = (top_bits == '0) || (&top_bits);

  always_comb begin
    if (in_range)       ofs_out = shr[DW-1:0];
    else if (shr[PW-1]) ofs_out = {1'b1, {(DW-1){1'b0}}};
    else                ofs_out = {1'b0, {(DW-1){1'b1}}};
  end

endmodule

// File: rtl/calseq_fsm.sv
module calseq_fsm
  import calseq_pkg::*;
#(
  parameter int unsigned DW    = 24,
  parameter int unsigned GFRAC = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          cfg_hpf,
  input  logic          cfg_ac_req,
  input  logic          cfg_dc_gain,
  input  logic          cfg_fix_mul,
  input  logic          dco_done,
  input  logic          aco_done,
  input  logic          gain_done,
  input  logic          wr_ready,
  input  logic          tmo_expired,
  input  logic [DW-1:0] prod_in,
  output logic          busy,
  output logic          fin,
  output logic          err,
  output logic [1:0]    err_code,
  output logic          dco_start,
  output logic          aco_start,
  output logic          gain_start,
  output logic          wr_valid,
  output logic [1:0]    wr_sel,
  output logic [DW-1:0] wr_data,
  output logic          tmo_clr,
  output logic          tmo_run
);
  localparam logic [DW-1:0] UNITY = DW'(64'd1 << GFRAC);

  st_e           st_q, st_d;
  plan_t         plan_q;
  logic          err_q;
  ecode_e        code_q;
  logic [DW-1:0] prod_q;
  logic          cfg_bad, accept, waiting, done_sel, abort;

  assign cfg_bad = cfg_hpf & cfg_dc_gain;
  assign accept  = (st_q == ST_IDLE) && go;
  assign waiting = (st_q == ST_WAIT_DCO) || (st_q == ST_WAIT_ACO) ||
                   (st_q == ST_WAIT_GAIN) || (st_q == ST_WAIT_RERUN);

  always_comb begin
    case (st_q)
      ST_WAIT_DCO:   done_sel = dco_done;
      ST_WAIT_ACO:   done_sel = aco_done;
      ST_WAIT_GAIN:  done_sel = gain_done;
      ST_WAIT_RERUN: done_sel = aco_done;
      default:       done_sel = 1'b0;
    endcase
  end

  assign abort = waiting && !done_sel && tmo_expired;

  // sequencing
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:
        if (go) st_d = cfg_bad ? ST_END : (cfg_hpf ? ST_ZERO_DCO : ST_UNIT_GAIN);
      ST_UNIT_GAIN:
        if (wr_ready) st_d = ST_KICK_DCO;
      ST_ZERO_DCO:
        if (wr_ready) st_d = plan_q.ac_req ? ST_KICK_ACO : ST_KICK_GAIN;
      ST_KICK_DCO:
        st_d = ST_WAIT_DCO;
      ST_WAIT_DCO:
        if (dco_done)         st_d = plan_q.ac_req ? ST_KICK_ACO : ST_KICK_GAIN;
        else if (tmo_expired) st_d = ST_END;
      ST_KICK_ACO:
        st_d = ST_WAIT_ACO;
      ST_WAIT_ACO:
        if (aco_done)         st_d = ST_KICK_GAIN;
        else if (tmo_expired) st_d = ST_END;
      ST_KICK_GAIN:
        st_d = ST_WAIT_GAIN;
      ST_WAIT_GAIN:
        if (gain_done) begin
          if (!plan_q.ac_req)      st_d = ST_END;
          else if (plan_q.fix_mul) st_d = ST_SCALE;
          else                     st_d = ST_ZERO_ACO;
        end else if (tmo_expired) st_d = ST_END;
      ST_ZERO_ACO:
        if (wr_ready) st_d = ST_KICK_RERUN;
      ST_KICK_RERUN:
        st_d = ST_WAIT_RERUN;
      ST_WAIT_RERUN:
        if (aco_done || tmo_expired) st_d = ST_END;
      ST_SCALE:
        st_d = ST_PUT_PROD;
      ST_PUT_PROD:
        if (wr_ready) st_d = ST_END;
      ST_END:
        st_d = ST_IDLE;
      default:
        st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      plan_q <= '0;
      err_q  <= 1'b0;
      code_q <= EC_NONE;
      prod_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        plan_q.ac_req  <= cfg_ac_req;
        plan_q.fix_mul <= cfg_fix_mul;
        err_q          <= cfg_bad;
        code_q         <= cfg_bad ? EC_CFG : EC_NONE;
      end else if (abort) begin
        err_q  <= 1'b1;
        code_q <= EC_TMO;
      end
      if (st_q == ST_SCALE) prod_q <= prod_in;
    end
  end

  // Moore outputs
  always_comb begin
    wr_valid = 1'b0;
    wr_sel   = SEL_ACO;
    wr_data  = '0;
    case (st_q)
      ST_ZERO_DCO:  begin wr_valid = 1'b1; wr_sel = SEL_DCO;  end
      ST_UNIT_GAIN: begin wr_valid = 1'b1; wr_sel = SEL_GAIN; wr_data = UNITY; end
      ST_ZERO_ACO:  begin wr_valid = 1'b1; wr_sel = SEL_ACO;  end
      ST_PUT_PROD:  begin wr_valid = 1'b1; wr_sel = SEL_ACO;  wr_data = prod_q; end
      default: ;
    endcase
  end

  assign dco_start  = (st_q == ST_KICK_DCO);
  assign aco_start  = (st_q == ST_KICK_ACO) || (st_q == ST_KICK_RERUN);
  assign gain_start = (st_q == ST_KICK_GAIN);
  assign tmo_clr    = dco_start || aco_start || gain_start;
  assign tmo_run    = waiting;
  assign busy       = (st_q != ST_IDLE);
  assign fin        = (st_q == ST_END);
  assign err        = err_q;
  assign err_code   = code_q;

endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl #(
  parameter int unsigned DW      = 24,
  parameter int unsigned GFRAC   = 22,
  parameter int unsigned TMO_CYC = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic          fin,
  output logic          err,
  output logic [1:0]    err_code,
  input  logic          cfg_hpf,
  input  logic          cfg_ac_req,
  input  logic          cfg_dc_gain,
  input  logic          cfg_fix_mul,
  input  logic [DW-1:0] aco_val,
  input  logic [DW-1:0] gain_val,
  output logic          dco_start,
  input  logic          dco_done,
  output logic          aco_start,
  input  logic          aco_done,
  output logic          gain_start,
  input  logic          gain_done,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [1:0]    wr_sel,
  output logic [DW-1:0] wr_data
);
  logic          tmo_clr, tmo_run, tmo_expired;
  logic [DW-1:0] prod;

  calseq_tmo #(.TMO_CYC(TMO_CYC)) tmo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmo_clr),
    .run     (tmo_run),
    .expired (tmo_expired)
  );

  calseq_ofs_scale #(.DW(DW), .GFRAC(GFRAC)) scale_i (
    .ofs_in  (aco_val),
    .gain_in (gain_val),
    .ofs_out (prod)
  );

  calseq_fsm #(.DW(DW), .GFRAC(GFRAC)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .cfg_hpf     (cfg_hpf),
    .cfg_ac_req  (cfg_ac_req),
    .cfg_dc_gain (cfg_dc_gain),
    .cfg_fix_mul (cfg_fix_mul),
    .dco_done    (dco_done),
    .aco_done    (aco_done),
    .gain_done   (gain_done),
    .wr_ready    (wr_ready),
    .tmo_expired (tmo_expired),
    .prod_in     (prod),
    .busy        (busy),
    .fin         (fin),
    .err         (err),
    .err_code    (err_code),
    .dco_start   (dco_start),
    .aco_start   (aco_start),
    .gain_start  (gain_start),
    .wr_valid    (wr_valid),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .tmo_clr     (tmo_clr),
    .tmo_run     (tmo_run)
  );

endmodule

// File: rtl/calseq_ctrl_chk.sv
module calseq_ctrl_chk #(
  parameter int unsigned DW    = 24,
  parameter int unsigned GFRAC = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          busy,
  input logic          fin,
  input logic          err,
  input logic [1:0]    err_code,
  input logic          cfg_hpf,
  input logic          cfg_dc_gain,
  input logic          dco_start,
  input logic          aco_start,
  input logic          gain_start,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [1:0]    wr_sel,
  input logic [DW-1:0] wr_data
);
  localparam logic [DW-1:0] UNITY = DW'(64'd1 << GFRAC);

  p_start_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dco_start, aco_start, gain_start}));

  p_kick_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_start |=> !gain_start);

  p_start_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dco_start || aco_start || gain_start || wr_valid) |-> busy);

  p_fin_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!busy && !fin));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_sel) && $stable(wr_data)));

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && cfg_hpf && cfg_dc_gain) |=> (fin && err && err_code == 2'd1));

  p_unity_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd2) |-> (wr_data == UNITY));

  p_zero_dco_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel == 2'd0) |-> (wr_data == '0));

endmodule

bind calseq_ctrl calseq_ctrl_chk #(.DW(DW), .GFRAC(GFRAC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .go          (go),
  .busy        (busy),
  .fin         (fin),
  .err         (err),
  .err_code    (err_code),
  .cfg_hpf     (cfg_hpf),
  .cfg_dc_gain (cfg_dc_gain),
  .dco_start   (dco_start),
  .aco_start   (aco_start),
  .gain_start  (gain_start),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data)
);

// File: tb/calseq_ctrl_tb_top.sv
module calseq_ctrl_tb_top;
  localparam int DW  = 24;
  localparam int GF  = 22;
  localparam int TMO = 40;
  localparam int NV  = 9;

  // {hpf, ac_req, dc_gain, fix_mul, aco[23:0], gain[23:0]}
  localparam logic [51:0] VEC [0:NV-1] = '{
    {4'b0000, 24'h000000, 24'h400000},
    {4'b1000, 24'h000000, 24'h400000},
    {4'b0100, 24'h000123, 24'h400000},
    {4'b1101, 24'h0003E8, 24'h600000},
    {4'b0101, 24'hFFFFFD, 24'h600000},
    {4'b1101, 24'h7FFFFF, 24'h800000},
    {4'b0101, 24'h800000, 24'h800000},
    {4'b1111, 24'h000010, 24'h400000},
    {4'b0111, 24'h000400, 24'h200000}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, go = 1'b0;
  logic cfg_hpf = 0, cfg_ac_req = 0, cfg_dc_gain = 0, cfg_fix_mul = 0;
  logic [DW-1:0] aco_val = '0, gain_val = '0;
  logic dco_done = 0, aco_done = 0, gain_done = 0, wr_ready = 0;
  logic busy, fin, err, dco_start, aco_start, gain_start, wr_valid;
  logic [1:0] err_code, wr_sel;
  logic [DW-1:0] wr_data;

  calseq_ctrl #(.DW(DW), .GFRAC(GF), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .fin(fin), .err(err),
    .err_code(err_code), .cfg_hpf(cfg_hpf), .cfg_ac_req(cfg_ac_req),
    .cfg_dc_gain(cfg_dc_gain), .cfg_fix_mul(cfg_fix_mul), .aco_val(aco_val),
    .gain_val(gain_val), .dco_start(dco_start), .dco_done(dco_done),
    .aco_start(aco_start), .aco_done(aco_done), .gain_start(gain_start),
    .gain_done(gain_done), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // event log: {kind, 4'h0, data}; kinds 1/2/3 = write sel 0/1/2, 4/5/6 = start dco/aco/gain
  logic [31:0] got_ev [0:15];
  logic [31:0] exp_ev [0:15];
  int n_got = 0, n_exp = 0;
  int dly_dco = 3, dly_aco = 5, dly_gain = 7;
  int c_dco = 0, c_aco = 0, c_gain = 0;
  logic [7:0] lfsr = 8'hA5;
  int cyc = 0, fin_cnt = 0, fin_cyc = 0, gst_cyc = 0;
  logic err_at_fin = 0;
  logic [1:0] code_at_fin = 0;
  bit pend = 0;
  logic [1:0] p_sel = 0;
  logic [DW-1:0] p_dat = 0;
  int hold_bad = 0;

  task automatic log_ev(input logic [31:0] e);
    if (n_got < 16) got_ev[n_got] = e;
    n_got++;
  endtask

  always @(negedge clk) begin
    bit r;
    logic [3:0] k;
    cyc++;
    if (pend && !(wr_valid && wr_sel == p_sel && wr_data == p_dat)) hold_bad++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    r = lfsr[0];
    wr_ready = r;
    pend = wr_valid && !r;
    p_sel = wr_sel;
    p_dat = wr_data;
    k = {2'b00, wr_sel} + 4'd1;
    if (wr_valid && r) log_ev({k, 4'h0, wr_data});
    dco_done = 0; aco_done = 0; gain_done = 0;
    if (c_dco > 0)  begin c_dco--;  if (c_dco == 0)  dco_done = 1;  end
    if (c_aco > 0)  begin c_aco--;  if (c_aco == 0)  aco_done = 1;  end
    if (c_gain > 0) begin c_gain--; if (c_gain == 0) gain_done = 1; end
    if (dco_start)  begin log_ev({4'd4, 28'd0}); c_dco = dly_dco; end
    if (aco_start)  begin log_ev({4'd5, 28'd0}); c_aco = dly_aco; end
    if (gain_start) begin log_ev({4'd6, 28'd0}); c_gain = dly_gain; gst_cyc = cyc; end
    if (fin) begin
      fin_cnt++; fin_cyc = cyc; err_at_fin = err; code_at_fin = err_code;
    end
  end

  function automatic logic [DW-1:0] model_fix(input logic [DW-1:0] a, input logic [DW-1:0] g);
    longint sa, p;
    sa = longint'($signed(a));
    p  = (sa * longint'({40'd0, g})) >>> GF;
    if (p > 64'sd8388607)  p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p[DW-1:0];
  endfunction

  task automatic push_exp(input logic [31:0] e);
    exp_ev[n_exp] = e;
    n_exp++;
  endtask

  task automatic build_exp(input bit hpf, ac, dcg, fix, input logic [DW-1:0] a, g);
    n_exp = 0;
    if (hpf && dcg) return;
    if (hpf) push_exp({4'd1, 28'd0});
    else begin push_exp({4'd3, 4'h0, 24'h400000}); push_exp({4'd4, 28'd0}); end
    if (ac) push_exp({4'd5, 28'd0});
    push_exp({4'd6, 28'd0});
    if (ac) begin
      if (!fix) begin push_exp({4'd2, 28'd0}); push_exp({4'd5, 28'd0}); end
      else push_exp({4'd2, 4'h0, model_fix(a, g)});
    end
  endtask

  function automatic string ev_tag(input logic [31:0] e, input bit fix);
    case (e[31:28])
      4'd1: return "R2 dco zero write";
      4'd2: return fix ? "R7/R8 scaled aco write" : "R6 aco zero write";
      4'd3: return "R3 unity gain write";
      4'd4: return "R3 dco start";
      4'd5: return "R4 aco start";
      default: return "R5 gain start";
    endcase
  endfunction

  // one run; keep = expected events kept (timeout truncation), disturb = R13 stimulus
  task automatic run_one(input bit hpf, ac, dcg, fix, input logic [DW-1:0] a, g,
                         input int keep, input logic [1:0] exp_code, input bit disturb);
    int f0;
    build_exp(hpf, ac, dcg, fix, a, g);
    if (keep >= 0) n_exp = keep;
    @(negedge clk);
    n_got = 0; f0 = fin_cnt;
    cfg_hpf = hpf; cfg_ac_req = ac; cfg_dc_gain = dcg; cfg_fix_mul = fix;
    aco_val = a; gain_val = g; go = 1;
    @(negedge clk);
    go = 0;
    if (disturb) begin
      @(negedge clk); @(negedge clk);
      cfg_hpf = !hpf; cfg_ac_req = !ac; cfg_fix_mul = !fix; cfg_dc_gain = 1; go = 1;
      @(negedge clk);
      go = 0;
    end
    for (int i = 0; i < 3000 && fin_cnt == f0; i++) @(posedge clk);
    @(negedge clk); @(negedge clk);
    @(posedge clk);
    chk(fin_cnt == f0 + 1, "R1 one fin per run", fin_cnt - f0, 1);
    chk(!busy, "R1 busy low after fin", busy, 0);
    chk(n_got == n_exp, disturb ? "R13 event count" : "R4/R5 event count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got && i < 16; i++)
      chk(got_ev[i] == exp_ev[i], disturb ? "R13 event" : ev_tag(exp_ev[i], fix), got_ev[i], exp_ev[i]);
    chk(code_at_fin == exp_code,
        exp_code == 2'd1 ? "R9 err_code" : (exp_code == 2'd2 ? "R10 err_code" : "R12 err_code clear"),
        code_at_fin, exp_code);
    chk(err_at_fin == (exp_code != 0), "R12 err flag", err_at_fin, exp_code != 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, fin, err, wr_valid, dco_start, aco_start, gain_start} == 7'd0,
        "R12 reset outputs", {busy, fin, err, wr_valid, dco_start, aco_start, gain_start}, 0);
    chk(err_code == 2'd0, "R12 reset err_code", err_code, 0);

    for (int v = 0; v < NV; v++) begin
      logic [51:0] t;
      t = VEC[v];
      run_one(t[51], t[50], t[49], t[48], t[47:24], t[23:0], -1,
              (t[51] && t[49]) ? 2'd1 : 2'd0, 1'b0);
    end

    // R13 and R1: config change and extra go during a run
    run_one(0, 1, 0, 1, 24'h0003E8, 24'h600000, -1, 2'd0, 1'b1);

    // R10: gain unit never answers
    dly_gain = 0;
    run_one(1, 1, 0, 0, 24'h0, 24'h400000, 3, 2'd2, 1'b0);
    chk(fin_cyc - gst_cyc == TMO + 1, "R10 abort timing", fin_cyc - gst_cyc, TMO + 1);
    // R10 boundary: done in last allowed cycle is accepted; also R12 clear
    dly_gain = TMO;
    run_one(1, 0, 0, 0, 24'h0, 24'h400000, -1, 2'd0, 1'b0);
    // R10 boundary: one cycle late aborts
    dly_gain = TMO + 1;
    run_one(1, 0, 0, 0, 24'h0, 24'h400000, -1, 2'd2, 1'b0);
    chk(fin_cyc - gst_cyc == TMO + 1, "R10 late done abort timing", fin_cyc - gst_cyc, TMO + 1);
    dly_gain = 7;
    // R10: DC offset unit stalls, nothing after its start
    dly_dco = 0;
    run_one(0, 1, 0, 1, 24'h10, 24'h400000, 2, 2'd2, 1'b0);
    dly_dco = 3;
    repeat (TMO + 5) @(negedge clk);

    chk(hold_bad == 0, "R11 write held under back-pressure", hold_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule